// File: doc/BRIEF.md
# Buffered Serial Peripheral Interface Master

This block is a register-mapped master for the four-wire serial peripheral bus. It moves 8-bit words in both directions at once. Software writes outgoing words into an 8-entry transmit queue through a data window. The block shifts each word out most significant bit first and captures one incoming word for every word it sends. Captured words land in an 8-entry receive queue, which software drains through the same data window. Software polls a status word to see how full each queue is and whether the serial engine is still working. Chip select is a plain output that software drives elsewhere, so it is not part of this block.

The bit clock comes from a two-stage divider. An even prescale value P (2 to 254) is multiplied by (1 + R), where R is an 8-bit rate field. The bit clock period is therefore P·(1+R) system clock cycles, and each half period lasts (P/2)·(1+R) cycles. Clock polarity and phase can be set in any of the four combinations. A loopback switch feeds the outgoing line straight back into the capture path.

Registers sit at 32-bit-aligned offsets on a small bus. A write takes effect on the bus_wr clock edge. Read data is combinational from bus_addr. A read of the data window pops the receive queue on the clock edge where bus_rd is high.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the registers read back as follows. Control 0 (offset 0x00) reads 0x0007. Control 1 (offset 0x04) reads 0x0000. Prescale (offset 0x10) reads 0x0002. Status (offset 0x0C) reads 0x0003. Overrun (offset 0x14) reads 0x0000. sclk is low.
- R2: A write to prescale (offset 0x10) stores the written low byte with bit 0 forced to zero. A stored value below 2 becomes 2. For example, 7 reads back as 6, and both 0 and 1 read back as 2.
- R3: Control 0 holds the rate field R in bits 15:8, the phase bit in bit 7 and the polarity bit in bit 6. While a word is in flight, sclk toggles every (P/2)·(1+R) clock cycles, for exactly 16 toggles per word. Outside a word, sclk sits at the polarity bit.
- R4: Words leave on mosi most significant bit first. With phase 0, the input is captured on toggles 1, 3, …, 15 of a word and mosi moves on the even toggles. With phase 1, mosi moves on toggles 3, 5, …, 15 and the input is captured on the even toggles. mosi is high while no word is in flight.
- R5: Control 1 bit 3 selects loopback. When it is set, the captured word equals the word sent. When it is clear, the captured bits come from miso.
- R6: A write to the data window (offset 0x08) appends the low byte to the transmit queue. When 8 words are already queued, the write is dropped.
- R7: Control 1 bit 4 is the enable bit. A new word starts only while this bit is set and the transmit queue is not empty. Clearing the bit lets the word in flight finish and holds the remaining queued words.
- R8: Each finished word adds exactly one entry to the receive queue. A read of the data window returns the oldest entry in bits 7:0 and removes it. A read of the empty queue returns 0.
- R9: The busy flag stays set while a word is in flight or any word is still queued for sending.
- R10: A word that finishes while 8 words are already received is discarded. It sets bit 2 of offset 0x14. Any write to offset 0x14 clears that bit.
- R11: The status word bits are: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at offset 0x08) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong divider count or edge counter shows up on sclk within one half period. Because sclk and mosi are compared against a reference model on every clock, such a fault is caught in the same cycle. A wrong capture edge or shift order corrupts the received byte, which the bench sees at the next data-window read after the word finishes. A miscount in a queue, or a wrong full or empty decision, shows up in the status word or as a dropped or extra byte. In the overrun case it also shows up in offset 0x14. These faults surface only once the queue is filled to its boundary, so the bench deliberately fills both queues to 8 entries and then goes one past.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] A_CTL0 = AW'(5'h00);
  localparam logic [AW-1:0] A_CTL1 = AW'(5'h04);
  localparam logic [AW-1:0] A_DATA = AW'(5'h08);
  localparam logic [AW-1:0] A_STAT = AW'(5'h0C);
  localparam logic [AW-1:0] A_PRE  = AW'(5'h10);
  localparam logic [AW-1:0] A_OVR  = AW'(5'h14);

  logic [15:0] ctl0;
  logic [6:0]  ctl1;
  logic [7:0]  cps;
  logic        ovr;

  logic [7:0]  tx_mem [DEPTH];
  logic [7:0]  rx_mem [DEPTH];
  logic [PW-1:0] tx_rd, tx_wr, rx_rd, rx_wr;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic        active, tgl;
  logic [15:0] cnt;
  logic [3:0]  edges;
  logic [7:0]  txsh, rxsh;

  wire pol = ctl0[6];
  wire pha = ctl0[7];
  wire en  = ctl1[4];
  wire lb  = ctl1[3];

  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == FULL);
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL);
  wire busy     = active | ~tx_empty;

  wire [15:0] half = {9'd0, cps[7:1]} * ({8'd0, ctl0[15:8]} + 16'd1);

  wire tx_push  = bus_wr && (bus_addr == A_DATA) && !tx_full;
  wire start    = en && !active && !tx_empty;
  wire rx_pop   = bus_rd && (bus_addr == A_DATA) && !rx_empty;
  wire edge_hit = active && (cnt == half - 16'd1);
  wire fin      = edge_hit && (edges == 4'd15);
  wire rx_push  = fin && !rx_full;
  wire ovr_set  = fin && rx_full;

  wire miso_in   = lb ? txsh[7] : miso;
  wire sample_now = pha ? edges[0] : ~edges[0];
  wire shift_now  = pha ? (~edges[0] && (edges != 4'd0)) : edges[0];
  wire [7:0] rx_next = sample_now ? {rxsh[6:0], miso_in} : rxsh;

  assign sclk = pol ^ tgl;
  assign mosi = active ? txsh[7] : 1'b1;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wr] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wr] <= rx_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0   <= 16'h0007;
      ctl1   <= '0;
      cps    <= 8'd2;
      ovr    <= 1'b0;
      active <= 1'b0;
      tgl    <= 1'b0;
      cnt    <= '0;
      edges  <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      tx_rd  <= '0;
      tx_wr  <= '0;
      tx_cnt <= '0;
      rx_rd  <= '0;
      rx_wr  <= '0;
      rx_cnt <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTL0: ctl0 <= bus_wdata;
          A_CTL1: ctl1 <= bus_wdata[6:0];
          A_PRE:  cps  <= (bus_wdata[7:1] == 7'd0) ? 8'd2 : {bus_wdata[7:1], 1'b0};
          default: ;
        endcase
      end

      if (ovr_set) ovr <= 1'b1;
      else if (bus_wr && bus_addr == A_OVR) ovr <= 1'b0;

      if (start) begin
        txsh   <= tx_mem[tx_rd];
        tx_rd  <= nxt(tx_rd);
        active <= 1'b1;
        cnt    <= '0;
        edges  <= '0;
        tgl    <= 1'b0;
      end else if (active) begin
        if (edge_hit) begin
          cnt   <= '0;
          tgl   <= ~tgl;
          edges <= edges + 4'd1;
          rxsh  <= rx_next;
          if (shift_now) txsh <= {txsh[6:0], 1'b0};
          if (edges == 4'd15) active <= 1'b0;
        end else begin
          cnt <= cnt + 16'd1;
        end
      end

      if (tx_push) tx_wr <= nxt(tx_wr);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);

      if (rx_push) rx_wr <= nxt(rx_wr);
      if (rx_pop)  rx_rd <= nxt(rx_rd);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL0: bus_rdata = ctl0;
      A_CTL1: bus_rdata = {9'd0, ctl1};
      A_DATA: bus_rdata = rx_empty ? 16'd0 : {8'd0, rx_mem[rx_rd]};
      A_STAT: bus_rdata = {11'd0, busy, rx_full, ~rx_empty, ~tx_full, tx_empty};
      A_PRE:  bus_rdata = {8'd0, cps};
      A_OVR:  bus_rdata = {13'd0, ovr, 2'b00};
      default: bus_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic [15:0]   cnt,
  input logic [3:0]    edges,
  input logic          sclk,
  input logic          pol,
  input logic          en,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          ovr
);
  // R6
  a_r6_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  // R10
  a_r10_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  // R3
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sclk == pol));
  // R3
  a_r3_steady_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != 16'd0 && $stable(pol)) |-> $stable(sclk));
  // R7
  a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(en));
  // R10
  a_r10_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past(rx_cnt) == CW'(DEPTH)));
  // R4
  a_r4_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(edges) == 4'd15));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .cnt(cnt), .edges(edges),
  .sclk(sclk), .pol(pol), .en(en), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ovr(ovr)
);

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [4:0]  b_addr;
  logic        b_wr, b_rd;
  logic [15:0] b_wdata;
  wire  [15:0] b_rdata;
  wire         sclk, mosi;
  wire         miso = ~mosi;

  int checks = 0;
  int fails  = 0;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // reference model
  logic [7:0]  mtx[$];
  logic [7:0]  mrx[$];
  logic [15:0] m_c0;
  logic [6:0]  m_c1;
  logic [7:0]  m_cps, m_sh, m_rx;
  logic        m_ovr, m_act, m_tgl, m_inb, m_fin, m_st;
  int          m_cnt, m_edge, m_hl, m_e, m_otx, m_orx;

  always @(posedge clk) begin
    if (!rst_n) begin
      mtx.delete(); mrx.delete();
      m_c0 = 16'h0007; m_c1 = '0; m_cps = 8'd2; m_ovr = 0; m_act = 0; m_tgl = 0;
      m_cnt = 0; m_edge = 0; m_sh = 0; m_rx = 0;
    end else begin
      m_hl  = (int'(m_cps) / 2) * (int'(m_c0[15:8]) + 1);
      m_otx = mtx.size();
      m_orx = mrx.size();
      m_fin = 0;
      m_st  = m_c1[4] && !m_act && m_otx != 0;
      if (m_st) begin
        m_sh = mtx.pop_front(); m_act = 1; m_cnt = 0; m_edge = 0; m_tgl = 0;
      end else if (m_act) begin
        if (m_cnt == m_hl - 1) begin
          m_e = m_edge + 1; m_cnt = 0; m_tgl = ~m_tgl;
          m_inb = m_c1[3] ? m_sh[7] : ~m_sh[7];
          if (m_c0[7] ? (m_e % 2 == 0) : (m_e % 2 == 1)) m_rx = {m_rx[6:0], m_inb};
          if (m_c0[7] ? (m_e % 2 == 1 && m_e != 1) : (m_e % 2 == 0)) m_sh = {m_sh[6:0], 1'b0};
          if (m_e == 16) begin m_act = 0; m_edge = 0; m_fin = 1; end
          else m_edge = m_e;
        end else m_cnt++;
      end
      if (b_rd && b_addr == 5'h08 && m_orx != 0) void'(mrx.pop_front());
      if (b_wr && b_addr == 5'h14) m_ovr = 0;
      if (m_fin) begin
        if (m_orx == 8) m_ovr = 1;
        else mrx.push_back(m_rx);
      end
      if (b_wr && b_addr == 5'h08 && m_otx != 8) mtx.push_back(b_wdata[7:0]);
      if (b_wr && b_addr == 5'h00) m_c0 = b_wdata;
      if (b_wr && b_addr == 5'h04) m_c1 = b_wdata[6:0];
      if (b_wr && b_addr == 5'h10) m_cps = (b_wdata[7:1] == 0) ? 8'd2 : {b_wdata[7:1], 1'b0};
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R3 R4: per-clock comparison of the serial lines
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", int'(sclk), int'(m_c0[6] ^ m_tgl), "sclk vs model");
      chk("R4", int'(mosi), m_act ? int'(m_sh[7]) : 1, "mosi vs model");
    end
  end

  // sclk toggle monitor
  int cyc = 0, last_t = 0, gap = 0, ntog = 0;
  logic sclk_d = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sclk !== sclk_d) begin gap = cyc - last_t; last_t = cyc; ntog++; end
    sclk_d = sclk;
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    b_addr = a; b_rd = 1'b1;
    #1 v = b_rdata;
    @(negedge clk);
    b_rd = 1'b0;
  endtask

  function automatic int model_status();
    return {27'd0, (m_act || mtx.size() != 0), (mrx.size() == 8), (mrx.size() != 0),
            (mtx.size() != 8), (mtx.size() == 0)};
  endfunction

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(5'h0C, s);
      if (!s[4]) return;
    end
    chk("R9", 1, 0, "busy never cleared");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [15:0] v;
  logic [7:0]  bytes [9];

  initial begin
    rst_n = 1'b0; b_addr = '0; b_wr = 0; b_rd = 0; b_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R11 status encoding
    rd(5'h00, v); chk("R1", v, 16'h0007, "ctl0 reset");
    rd(5'h04, v); chk("R1", v, 0, "ctl1 reset");
    rd(5'h10, v); chk("R1", v, 2, "prescale reset");
    rd(5'h0C, v); chk("R11", v, 16'h0003, "status reset");
    rd(5'h14, v); chk("R1", v, 0, "overrun reset");
    chk("R1", int'(sclk), 0, "sclk reset");

    // R2 prescale even and minimum
    wr(5'h10, 16'h0007); rd(5'h10, v); chk("R2", v, 6, "prescale 7");
    wr(5'h10, 16'h0000); rd(5'h10, v); chk("R2", v, 2, "prescale 0");
    wr(5'h10, 16'h0001); rd(5'h10, v); chk("R2", v, 2, "prescale 1");
    wr(5'h10, 16'h0004);

    // R7 no start while disabled
    wr(5'h00, 16'h0207);
    wr(5'h08, 16'h00A5);
    repeat (60) @(negedge clk);
    rd(5'h0C, v); chk("R7", v, 16'h0012, "held while disabled");
    chk("R7", v, model_status(), "status vs model");

    // R3 timing, R5 normal path, R8 one entry per word
    ntog = 0;
    wr(5'h04, 16'h0010);
    wait_idle();
    chk("R3", gap, 6, "half period cycles");
    chk("R3", ntog, 16, "toggles per word");
    rd(5'h0C, v); chk("R11", v, 16'h0007, "status one received");
    rd(5'h08, v); chk("R5", v, 16'h005A, "miso data captured");
    rd(5'h08, v); chk("R8", v, 0, "empty read returns 0");

    // R4 all four modes
    for (int m = 0; m < 4; m++) begin
      logic [7:0] tb;
      tb = 8'hC3 ^ 8'(m * 37);
      wr(5'h00, {8'd1, m[1], m[0], 6'h07});
      wr(5'h08, {8'd0, tb});
      wait_idle();
      rd(5'h08, v); chk("R4", v, {8'd0, ~tb}, "mode word");
    end

    // R5 loopback
    wr(5'h04, 16'h0018);
    wr(5'h08, 16'h003C);
    wait_idle();
    rd(5'h08, v); chk("R5", v, 16'h003C, "loopback word");
    wr(5'h04, 16'h0010);

    // R9 busy while last word in flight
    wr(5'h08, 16'h0081);
    repeat (8) @(negedge clk);
    rd(5'h0C, v); chk("R9", v, 16'h0013, "busy in flight");
    wait_idle();
    rd(5'h08, v); chk("R8", v, 16'h007E, "in-flight word");

    // R7 disable mid-word
    wr(5'h08, 16'h0011);
    wr(5'h08, 16'h0022);
    repeat (10) @(negedge clk);
    wr(5'h04, 16'h0000);
    repeat (200) @(negedge clk);
    rd(5'h0C, v); chk("R7", v, 16'h0016, "held after disable");
    rd(5'h08, v); chk("R7", v, 16'h00EE, "finished word");
    wr(5'h04, 16'h0010);
    wait_idle();
    rd(5'h08, v); chk("R7", v, 16'h00DD, "held word later");

    // R6 tx full drop, R10 overrun
    wr(5'h04, 16'h0000);
    for (int i = 0; i < 9; i++) begin
      bytes[i] = 8'(8'h10 + i * 9);
      wr(5'h08, {8'd0, bytes[i]});
    end
    rd(5'h0C, v); chk("R6", v, 16'h0010, "tx full status");
    wr(5'h04, 16'h0010);
    wait_idle();
    rd(5'h0C, v); chk("R6", v, 16'h000F, "eight words only");
    wr(5'h08, 16'h00F0);
    wait_idle();
    rd(5'h14, v); chk("R10", v, 16'h0004, "overrun set");
    wr(5'h14, 16'h0000);
    rd(5'h14, v); chk("R10", v, 0, "overrun cleared");
    for (int i = 0; i < 8; i++) begin
      rd(5'h08, v); chk("R10", v, {8'd0, ~bytes[i]}, "kept words");
    end
    rd(5'h08, v); chk("R6", v, 0, "ninth word dropped");
    rd(5'h0C, v); chk("R11", v, model_status(), "final status vs model");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule